// File: doc/BRIEF.md
# Interrupt Event Queue Writer

The block records events for a set of channels as entries in a circular table of two-halfword entries. The table is held in internal storage. On the producer side it accepts one set of sub-channel event pulses per cycle. Each set comes with a 16-bit channel code, an 8-bit sub-channel identifier and a per-event enable mask. It also accepts a separate channel-level error report. Each accepted event becomes an entry, which is written in one cycle into the slot the write pointer names.

A host owns the other side through a halfword-wide read/write port. Before traffic starts, the host marks the last slot of the ring by setting its wrap flag. During operation it reads each pending entry and then clears that entry's valid flag, which hands the slot back to the producer. The ring length is set by the wrap flags stored in the table, not by the physical depth. A level interrupt tells the host that work is waiting. A one-cycle overflow pulse reports every event that found its slot still occupied.

Top module: `irq_evq_writer`

## Requirements
- R1: A posted entry is written in a single cycle. Halfword 0 is laid out as bit 15 = valid (set to 1), bit 14 = 0, bit 13 = wrap flag kept from the slot, bits 12:5 = sub-channel ID and bits 4:0 = flags {tx-not-ready, rx-buffer, busy, tx-buffer, rx-frame} from bit 4 down to bit 0. Halfword 1 holds the channel code.
- R2: Tx-not-ready, rx-buffer, tx-buffer and rx-frame are each recorded only when their own enable input is high. Busy is always recorded. When no flag survives the masking, no sub-channel entry is made.
- R3: All sub-channel event pulses in the same cycle are merged into one entry.
- R4: An error entry has bits 12:5 = 0 and bits 4:0 = the error code, with the error channel in halfword 1. It is made only when err_valid and err_en are both high.
- R5: When a sub-channel entry and an error entry arise in the same cycle, the sub-channel entry goes to the current slot and the error entry goes to the slot after it. Both are written in that cycle.
- R6: The producer never writes a slot whose valid flag is set. Each entry that cannot be placed is dropped, and ovf goes high for one cycle on the following cycle. Freeness is judged on the flags as they stood before the cycle, so a host clear in the same cycle does not admit the event.
- R7: After writing a slot whose wrap flag is set, or the physically last slot, the pointer returns to slot 0. Otherwise it advances by one.
- R8: irq is high exactly while at least one slot has its valid flag set.
- R9: host_addr = {slot, half}, where half 0 selects halfword 0 and half 1 selects halfword 1. A read returns data on host_rdata one cycle later. A write replaces the whole halfword. If the producer writes the same slot in the same cycle, the producer's write wins.
- R10: Synchronous active-low reset clears every slot to zero, sets the pointer to slot 0 and drives irq and ovf low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_chan | input | 16 | Channel code for sub-channel events |
| ev_sub | input | 8 | Sub-channel ID for sub-channel events |
| ev_tbnr | input | 1 | Transmit buffer not ready pulse |
| ev_rxb | input | 1 | Receive buffer pulse |
| ev_busy | input | 1 | Busy / packets discarded pulse |
| ev_txb | input | 1 | Transmit buffer pulse |
| ev_rxf | input | 1 | Received frame pulse |
| en_tbnr | input | 1 | Enable for not-ready flag |
| en_rxb | input | 1 | Enable for receive-buffer flag |
| en_txb | input | 1 | Enable for transmit-buffer flag |
| en_rxf | input | 1 | Enable for received-frame flag |
| err_valid | input | 1 | Channel error report pulse |
| err_chan | input | 16 | Channel code of the error |
| err_code | input | 5 | Error code |
| err_en | input | 1 | Global error posting enable |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | $clog2(DEPTH)+1 | {slot, half} |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the read |
| irq | output | 1 | Level interrupt: some entry pending |
| ovf | output | 1 | One-cycle pulse for each dropped event cycle |

## Verification
Two functions can fall in the same cycle: posting into the slot under the pointer, and the host clearing that same slot. The bench fills the ring, then strobes an event and a host clear of the pointer slot on one clock edge. It expects ovf to pulse, the event to be lost, and the next event to land in the freed slot. It also raises a sub-channel event and an error together while the second slot is still held. Here it expects the first entry to be stored and the error to be reported as an overflow.

// File: rtl/evq_pkg.sv
// Shared constants and types for the interrupt event queue writer.
// Assumes 16-bit halfwords; the bit layout of halfword 0 is decoded by the host.
package evq_pkg;
    localparam int HW_W     = 16;
    localparam int SUB_W    = 8;
    localparam int CODE_W   = 5;
    localparam int LO_W     = SUB_W + CODE_W;  // bits 12:0 of halfword 0
    localparam int VLD_BIT  = 15;
    localparam int WRAP_BIT = 13;

    // Event flags in their halfword-0 order, bit 4 down to bit 0.
    typedef struct packed {
        logic tbnr;
        logic rxb;
        logic busy;
        logic txb;
        logic rxf;
    } ev_flags_t;
endpackage

// File: rtl/evq_entry_fmt.sv
// Builds the low 13 bits and channel code of up to two entries per cycle.
// Purely combinational. Assumes the caller adds the valid and wrap bits.
module evq_entry_fmt
    import evq_pkg::*;
(
    input  logic [HW_W-1:0]   ev_chan,
    input  logic [SUB_W-1:0]  ev_sub,
    input  ev_flags_t         ev_raw,
    input  logic              en_tbnr,
    input  logic              en_rxb,
    input  logic              en_txb,
    input  logic              en_rxf,
    input  logic              err_valid,
    input  logic [HW_W-1:0]   err_chan,
    input  logic [CODE_W-1:0] err_code,
    input  logic              err_en,
    output logic              need_one,
    output logic              need_two,
    output logic [LO_W-1:0]   first_lo,
    output logic [HW_W-1:0]   first_ch,
    output logic [LO_W-1:0]   second_lo,
    output logic [HW_W-1:0]   second_ch
);
    ev_flags_t flags;
    logic      want_sub;
    logic      want_err;

    // Apply per-event enables; busy has no enable.
    always_comb begin
        flags.tbnr = ev_raw.tbnr & en_tbnr;
        flags.rxb  = ev_raw.rxb  & en_rxb;
        flags.busy = ev_raw.busy;
        flags.txb  = ev_raw.txb  & en_txb;
        flags.rxf  = ev_raw.rxf  & en_rxf;
    end

    // Select entry contents: the sub-channel entry goes first, the error entry second.
    always_comb begin
        want_sub  = |flags;
        want_err  = err_valid & err_en;
        need_one  = want_sub | want_err;
        need_two  = want_sub & want_err;
        second_lo = {{SUB_W{1'b0}}, err_code};
        second_ch = err_chan;
        first_lo  = want_sub ? {ev_sub, flags} : second_lo;
        first_ch  = want_sub ? ev_chan : err_chan;
    end
endmodule

// File: rtl/evq_ptr_ctrl.sv
// Write pointer, slot-free check and overflow pulse for the event ring.
// Assumes DEPTH >= 2. The next slot comes from the stored wrap flags, and
// the physically last slot also returns to 0.
module evq_ptr_ctrl #(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DEPTH-1:0]         vld_vec,
    input  logic [DEPTH-1:0]         wrp_vec,
    input  logic                     need_one,
    input  logic                     need_two,
    output logic                     we_a,
    output logic [$clog2(DEPTH)-1:0] idx_a,
    output logic                     we_b,
    output logic [$clog2(DEPTH)-1:0] idx_b,
    output logic                     ovf_q
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] n1;
    logic [IDX_W-1:0] n2;
    logic             free0;
    logic             free1;
    logic             drop;

    // Look ahead two slots and decide which writes may proceed.
    always_comb begin
        n1    = (wrp_vec[ptr_q] || ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
        n2    = (wrp_vec[n1] || n1 == LAST) ? '0 : n1 + IDX_W'(1);
        free0 = !vld_vec[ptr_q];
        free1 = !vld_vec[n1] && (n1 != ptr_q);
        we_a  = need_one && free0;
        we_b  = need_two && free0 && free1;
        idx_a = ptr_q;
        idx_b = n1;
        drop  = need_one && !(need_two ? we_b : we_a);
    end

    // Advance the pointer past every slot written; register the overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= drop;
            if (we_b)      ptr_q <= n2;
            else if (we_a) ptr_q <= n1;
        end
    end

    AST_DROP_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (need_one && vld_vec[ptr_q]) |=> ovf_q); // R6
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && !we_b && wrp_vec[ptr_q]) |=> (ptr_q == '0)); // R7
    AST_PAIR_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        we_b |-> we_a); // R5
endmodule

// File: rtl/evq_slot_table.sv
// Slot storage: DEPTH entries of two halfwords, with a host port and two producer ports.
// Producer writes keep the slot's wrap flag and set valid. On a collision
// they override a host write to the same halfword.
module evq_slot_table
    import evq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     h_en,
    input  logic                     h_we,
    input  logic [$clog2(DEPTH):0]   h_addr,
    input  logic [HW_W-1:0]          h_wdata,
    output logic [HW_W-1:0]          h_rdata,
    input  logic                     pa_we,
    input  logic [$clog2(DEPTH)-1:0] pa_idx,
    input  logic [LO_W-1:0]          pa_lo,
    input  logic [HW_W-1:0]          pa_ch,
    input  logic                     pb_we,
    input  logic [$clog2(DEPTH)-1:0] pb_idx,
    input  logic [LO_W-1:0]          pb_lo,
    input  logic [HW_W-1:0]          pb_ch,
    output logic [DEPTH-1:0]         vld_vec,
    output logic [DEPTH-1:0]         wrp_vec,
    output logic                     any_vld
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [HW_W-1:0]  hw0_q [DEPTH];
    logic [HW_W-1:0]  hw1_q [DEPTH];
    logic [IDX_W-1:0] h_slot;
    logic             h_half;

    assign h_slot = h_addr[IDX_W:1];
    assign h_half = h_addr[0];

    // Expose the per-slot valid and wrap flags.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_flags
            assign vld_vec[i] = hw0_q[i][VLD_BIT];
            assign wrp_vec[i] = hw0_q[i][WRAP_BIT];
        end
    endgenerate

    assign any_vld = |vld_vec;

    // Apply host accesses first, then producer writes so that they win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hw0_q[i] <= '0;
                hw1_q[i] <= '0;
            end
            h_rdata <= '0;
        end else begin
            if (h_en && int'(h_slot) < DEPTH) begin
                if (h_we) begin
                    if (h_half) hw1_q[h_slot] <= h_wdata;
                    else        hw0_q[h_slot] <= h_wdata;
                end else begin
                    h_rdata <= h_half ? hw1_q[h_slot] : hw0_q[h_slot];
                end
            end
            if (pa_we) begin
                hw0_q[pa_idx] <= {1'b1, 1'b0, hw0_q[pa_idx][WRAP_BIT], pa_lo};
                hw1_q[pa_idx] <= pa_ch;
            end
            if (pb_we) begin
                hw0_q[pb_idx] <= {1'b1, 1'b0, hw0_q[pb_idx][WRAP_BIT], pb_lo};
                hw1_q[pb_idx] <= pb_ch;
            end
        end
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pa_we |-> !vld_vec[pa_idx]); // R6
    AST_NO_OVERWRITE_B: assert property (@(posedge clk) disable iff (!rst_n)
        pb_we |-> !vld_vec[pb_idx]); // R6
    AST_ENTRY_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        pa_we |=> hw0_q[$past(pa_idx)][VLD_BIT]); // R1
    AST_DISTINCT_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_we && pb_we) |-> (pa_idx != pb_idx)); // R5
endmodule

// File: rtl/irq_evq_writer.sv
// Top level of the interrupt event queue writer. It formats events, places them
// into free ring slots, reports drops and raises a level interrupt.
// Assumes the host sets the wrap flag of the last ring slot before traffic.
module irq_evq_writer
    import evq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            ev_chan,
    input  logic [7:0]             ev_sub,
    input  logic                   ev_tbnr,
    input  logic                   ev_rxb,
    input  logic                   ev_busy,
    input  logic                   ev_txb,
    input  logic                   ev_rxf,
    input  logic                   en_tbnr,
    input  logic                   en_rxb,
    input  logic                   en_txb,
    input  logic                   en_rxf,
    input  logic                   err_valid,
    input  logic [15:0]            err_chan,
    input  logic [4:0]             err_code,
    input  logic                   err_en,
    input  logic                   host_en,
    input  logic                   host_we,
    input  logic [$clog2(DEPTH):0] host_addr,
    input  logic [15:0]            host_wdata,
    output logic [15:0]            host_rdata,
    output logic                   irq,
    output logic                   ovf
);
    localparam int IDX_W = $clog2(DEPTH);

    ev_flags_t        ev_raw;
    logic             need_one;
    logic             need_two;
    logic [LO_W-1:0]  first_lo;
    logic [LO_W-1:0]  second_lo;
    logic [HW_W-1:0]  first_ch;
    logic [HW_W-1:0]  second_ch;
    logic             we_a;
    logic             we_b;
    logic [IDX_W-1:0] idx_a;
    logic [IDX_W-1:0] idx_b;
    logic [DEPTH-1:0] vld_vec;
    logic [DEPTH-1:0] wrp_vec;

    // Gather the raw event pulses into the flag order.
    assign ev_raw = '{tbnr: ev_tbnr, rxb: ev_rxb, busy: ev_busy, txb: ev_txb, rxf: ev_rxf};

    evq_entry_fmt u_fmt (
        .ev_chan  (ev_chan),
        .ev_sub   (ev_sub),
        .ev_raw   (ev_raw),
        .en_tbnr  (en_tbnr),
        .en_rxb   (en_rxb),
        .en_txb   (en_txb),
        .en_rxf   (en_rxf),
        .err_valid(err_valid),
        .err_chan (err_chan),
        .err_code (err_code),
        .err_en   (err_en),
        .need_one (need_one),
        .need_two (need_two),
        .first_lo (first_lo),
        .first_ch (first_ch),
        .second_lo(second_lo),
        .second_ch(second_ch)
    );

    evq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_vec (vld_vec),
        .wrp_vec (wrp_vec),
        .need_one(need_one),
        .need_two(need_two),
        .we_a    (we_a),
        .idx_a   (idx_a),
        .we_b    (we_b),
        .idx_b   (idx_b),
        .ovf_q   (ovf)
    );

    evq_slot_table #(.DEPTH(DEPTH)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .h_en   (host_en),
        .h_we   (host_we),
        .h_addr (host_addr),
        .h_wdata(host_wdata),
        .h_rdata(host_rdata),
        .pa_we  (we_a),
        .pa_idx (idx_a),
        .pa_lo  (first_lo),
        .pa_ch  (first_ch),
        .pb_we  (we_b),
        .pb_idx (idx_b),
        .pb_lo  (second_lo),
        .pb_ch  (second_ch),
        .vld_vec(vld_vec),
        .wrp_vec(wrp_vec),
        .any_vld(irq)
    );

    AST_IRQ_AFTER_POST: assert property (@(posedge clk) disable iff (!rst_n)
        we_a |=> irq); // R8
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_en && !ev_tbnr && !ev_rxb && !ev_busy && !ev_txb && !ev_rxf) |-> !we_a); // R4
    AST_OVF_ONE_CYCLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!need_one) |=> !ovf); // R6
endmodule

// File: tb/irq_evq_writer_tb_top.sv
`timescale 1ns/1ps
module irq_evq_writer_tb_top;
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH) + 1;
    localparam int RING_LAST = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic [15:0] ev_chan, err_chan, host_wdata, host_rdata;
    logic [7:0]  ev_sub;
    logic ev_tbnr, ev_rxb, ev_busy, ev_txb, ev_rxf;
    logic en_tbnr, en_rxb, en_txb, en_rxf;
    logic err_valid, err_en;
    logic [4:0] err_code;
    logic host_en, host_we;
    logic [AW-1:0] host_addr;
    logic irq, ovf;

    irq_evq_writer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_chan(ev_chan), .ev_sub(ev_sub),
        .ev_tbnr(ev_tbnr), .ev_rxb(ev_rxb), .ev_busy(ev_busy), .ev_txb(ev_txb), .ev_rxf(ev_rxf),
        .en_tbnr(en_tbnr), .en_rxb(en_rxb), .en_txb(en_txb), .en_rxf(en_rxf),
        .err_valid(err_valid), .err_chan(err_chan), .err_code(err_code), .err_en(err_en),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq), .ovf(ovf)
    );

    typedef struct {
        int          slot;
        logic [15:0] h0;
        logic [15:0] h1;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic mv[DEPTH];
    logic mw[DEPTH];
    int   mptr;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int mnext(input int p);
        return (mw[p] || p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    function automatic logic [15:0] mk_h0(input int slot, input logic [7:0] sub, input logic [4:0] fl);
        return {1'b1, 1'b0, mw[slot], sub, fl};
    endfunction

    task automatic host_read(input int slot, input bit half, output logic [15:0] val);
        @(negedge clk);
        host_en = 1; host_we = 0; host_addr = AW'({slot[AW-2:0], half});
        @(negedge clk);
        host_en = 0;
        val = host_rdata;
    endtask

    task automatic host_write(input int slot, input bit half, input logic [15:0] val);
        @(negedge clk);
        host_en = 1; host_we = 1; host_addr = AW'({slot[AW-2:0], half}); host_wdata = val;
        @(negedge clk);
        host_en = 0; host_we = 0;
    endtask

    // Driver: applies one event cycle, predicts entries and the overflow flag.
    task automatic fire(input logic [15:0] ch, input logic [7:0] sub, input logic [4:0] ev,
                        input logic [3:0] en, input logic ev_err, input logic e_en,
                        input logic [4:0] code, input logic [15:0] ech,
                        input bit clr, input int clr_slot, input logic [15:0] clr_val,
                        input string tag);
        logic [4:0] fl;
        bit ws, we, oka, okb, drop;
        int p, n1;
        @(negedge clk);
        ev_chan = ch; ev_sub = sub;
        {ev_tbnr, ev_rxb, ev_busy, ev_txb, ev_rxf} = ev;
        {en_tbnr, en_rxb, en_txb, en_rxf} = en;
        err_valid = ev_err; err_en = e_en; err_code = code; err_chan = ech;
        if (clr) begin
            host_en = 1; host_we = 1; host_addr = AW'({clr_slot[AW-2:0], 1'b0}); host_wdata = clr_val;
        end
        fl = {ev[4] & en[3], ev[3] & en[2], ev[2], ev[1] & en[1], ev[0] & en[0]};
        ws = |fl;
        we = ev_err && e_en;
        p = mptr; n1 = mnext(p);
        oka = !mv[p];
        okb = oka && !mv[n1] && (n1 != p);
        drop = 0;
        if (ws && we) begin
            if (oka) begin
                sb.push_back('{p, mk_h0(p, sub, fl), ch, tag}); mv[p] = 1; mptr = n1;
            end
            if (okb) begin
                sb.push_back('{n1, mk_h0(n1, 8'h00, code), ech, tag}); mv[n1] = 1; mptr = mnext(n1);
            end
            drop = !okb;
        end else if (ws || we) begin
            if (oka) begin
                sb.push_back('{p, ws ? mk_h0(p, sub, fl) : mk_h0(p, 8'h00, code), ws ? ch : ech, tag});
                mv[p] = 1; mptr = n1;
            end
            drop = !oka;
        end
        if (clr) mv[clr_slot] = 0;
        @(negedge clk);
        chk({tag, " ovf"}, 16'(ovf), 16'(drop));
        {ev_tbnr, ev_rxb, ev_busy, ev_txb, ev_rxf} = '0;
        err_valid = 0; host_en = 0; host_we = 0;
    endtask

    // Monitor: pops the oldest expected entry, compares both halfwords, frees the slot.
    task automatic monitor_pop();
        exp_t e;
        logic [15:0] v;
        e = sb.pop_front();
        host_read(e.slot, 1'b0, v);
        chk({e.tag, " hw0"}, v, e.h0);
        host_read(e.slot, 1'b1, v);
        chk({e.tag, " hw1"}, v, e.h1);
        host_write(e.slot, 1'b0, e.h0 & 16'h7FFF);
        mv[e.slot] = 0;
    endtask

    task automatic drain_all();
        while (sb.size() > 0) monitor_pop();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        rst_n = 0; ev_chan = 0; ev_sub = 0;
        {ev_tbnr, ev_rxb, ev_busy, ev_txb, ev_rxf} = '0;
        {en_tbnr, en_rxb, en_txb, en_rxf} = '0;
        err_valid = 0; err_en = 0; err_code = 0; err_chan = 0;
        host_en = 0; host_we = 0; host_addr = '0; host_wdata = '0;
        for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; mw[i] = 0; end
        mptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk("R10 irq", 16'(irq), 16'h0);
        chk("R10 ovf", 16'(ovf), 16'h0);
        host_read(0, 1'b0, v);
        chk("R10 slot0", v, 16'h0000);

        // R9: host write then read back; ring of six slots via wrap flag
        host_write(RING_LAST, 1'b0, 16'h2000);
        mw[RING_LAST] = 1;
        host_read(RING_LAST, 1'b0, v);
        chk("R9 readback", v, 16'h2000);

        // R1 R2: single enabled rx-buffer event
        fire(16'h1234, 8'h3C, 5'b01000, 4'b0100, 0, 0, 0, 0, 0, 0, 0, "R1");
        chk("R8 irq set", 16'(irq), 16'h1);
        drain_all();
        chk("R8 irq clear", 16'(irq), 16'h0);

        // R2: masked-off event creates nothing
        fire(16'h0001, 8'h11, 5'b10000, 4'b0111, 0, 0, 0, 0, 0, 0, 0, "R2");
        chk("R2 masked irq", 16'(irq), 16'h0);

        // R3: all pulses together merge into one entry
        fire(16'hA5A5, 8'hC3, 5'b11111, 4'b1111, 0, 0, 0, 0, 0, 0, 0, "R3");
        chk("R3 one entry", 16'(sb.size()), 16'h1);
        drain_all();
        chk("R3 irq clear", 16'(irq), 16'h0);

        // R2: busy is recorded with every enable low
        fire(16'h0F0F, 8'h7E, 5'b00100, 4'b0000, 0, 0, 0, 0, 0, 0, 0, "R2");
        drain_all();

        // R4: error disabled, then enabled
        fire(16'h0, 8'h0, 5'b0, 4'b0, 1, 0, 5'h15, 16'hBEEF, 0, 0, 0, "R4");
        chk("R4 gated irq", 16'(irq), 16'h0);
        fire(16'h0, 8'h0, 5'b0, 4'b0, 1, 1, 5'h15, 16'hBEEF, 0, 0, 0, "R4");
        drain_all();

        // R5: sub-channel and error together fill two slots (second carries wrap)
        fire(16'h5555, 8'h9A, 5'b00010, 4'b0010, 1, 1, 5'h0B, 16'hCAFE, 0, 0, 0, "R5");
        chk("R5 two entries", 16'(sb.size()), 16'h2);
        drain_all();

        // R7 R6: fill the ring, wrap to slot 0, then overflow
        for (int k = 0; k < 6; k++)
            fire(16'(16'h100 + k), 8'(k + 1), 5'b00001, 4'b0001, 0, 0, 0, 0, 0, 0, 0, "R7");
        fire(16'h0EEE, 8'hEE, 5'b00001, 4'b0001, 0, 0, 0, 0, 0, 0, 0, "R6");

        // R6: host clear of the pointer slot in the same cycle does not admit the event
        begin
            exp_t f;
            f = sb[0];
            fire(16'h0DDD, 8'hDD, 5'b00001, 4'b0001, 0, 0, 0, 0, 1, f.slot, f.h0 & 16'h7FFF, "R6");
            void'(sb.pop_front());
        end
        fire(16'h0CCC, 8'hCC, 5'b00001, 4'b0001, 0, 0, 0, 0, 0, 0, 0, "R6");
        drain_all();

        // R5 R6: second slot still held when a pair arrives
        for (int k = 0; k < 6; k++)
            fire(16'(16'h200 + k), 8'(k + 8'h40), 5'b01000, 4'b0100, 0, 0, 0, 0, 0, 0, 0, "R7");
        monitor_pop();
        fire(16'h7777, 8'h77, 5'b00010, 4'b0010, 1, 1, 5'h1F, 16'hF00D, 0, 0, 0, "R5");
        drain_all();
        chk("R8 final irq", 16'(irq), 16'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule